// File: doc/BRIEF.md
# Debug Monitor Serial Link

This block is the serial port of a debug monitor. One shared data line carries traffic in both directions, one direction at a time. Bytes travel as plain asynchronous frames: a low start bit, eight data bits with the least significant first, and a high stop bit. The line rests high between frames. One bit lasts a fixed number of bus clock cycles, 278 by default, and the same period is used for sending and for receiving.

The receiver also detects a break. A break is a frame whose data bits and stop bit are all low. The block does not deliver a break as a byte. It answers on its own. It drives the line high for two bit periods, then drives a ten-bit low pulse back to the host, then releases the line. A frame with a low stop bit and nonzero data is reported as a framing error, and its byte is dropped.

The host side of the chip sends a byte by presenting it with a start request while the busy output is low. The data line is modelled as an input sample plus an output value and an output enable. The pad, with its pull-up, lies outside this block.

Top module: `mon_serial_link`

## Requirements
- R1: Every transmitted bit lasts exactly BIT_CYC (278) bus clock cycles, and the receiver uses the same bit period.
- R2: A transmitted frame places bit 0 as a low start bit, bits 1 to 8 as tx_data bit 0 up to bit 7, and bit 9 as a high stop bit. line_oe is high only while a frame or a break response is in progress, and line_out carries the bit value without inversion.
- R3: The receiver starts on a falling edge of the line and confirms the start bit 139 cycles later. It then samples each data bit and the stop bit at mid-bit. When the stop bit is high, rx_valid pulses for one cycle and rx_data holds the received byte.
- R4: A low pulse on an idle line that is shorter than half a bit period produces no rx_valid, rx_ferr or brk_det.
- R5: A frame with all eight data bits low and a low stop bit pulses brk_det for one cycle. It raises no rx_valid and leaves rx_data unchanged.
- R6: A frame with a low stop bit and nonzero data pulses rx_ferr for one cycle. It raises no rx_valid and leaves rx_data unchanged.
- R7: Starting in the cycle after brk_det, line_oe is high and line_out is high for 2 bit periods (556 cycles). line_out is then low for 10 bit periods (2780 cycles), after which line_oe falls. tx_busy is high for the whole sequence.
- R8: tx_start is taken only while tx_busy is low. tx_busy then rises on the next clock edge and stays high for exactly 10 bit periods (2780 cycles), from the start of the start bit through the end of the stop bit. A tx_start that arrives while busy is ignored.
- R9: While the block drives the line, activity on line_in produces no rx_valid, rx_ferr or brk_det.
- R10: During reset and after it, line_oe and tx_busy are low, rx_valid, rx_ferr and brk_det are low, and rx_data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_in | input | 1 | Sampled level of the shared data line |
| line_out | output | 1 | Level driven onto the data line when line_oe is high |
| line_oe | output | 1 | Output enable for the data line |
| rx_data | output | 8 | Last byte received with a valid stop bit |
| rx_valid | output | 1 | One-cycle strobe: rx_data holds a new byte |
| rx_ferr | output | 1 | One-cycle strobe: frame dropped because of a low stop bit |
| brk_det | output | 1 | One-cycle strobe: break received, response starting |
| tx_data | input | 8 | Byte to transmit |
| tx_start | input | 1 | Transmit request, taken when tx_busy is low |
| tx_busy | output | 1 | Transmitter or break response in progress |

## Verification
Most internal faults in this block show up as timing errors at the line. An off-by-one in the bit counter moves every later edge on line_out, and the error grows by one cycle per bit. By the stop bit it amounts to ten cycles, and the falling edge of tx_busy lands on the wrong cycle. A receiver whose sampling point or bit order is wrong gives the wrong rx_data, or the wrong kind of strobe, within one frame time. An error in the break sequencer or in the receiver lock-out shows within a single break response as a wrong line level at some mid-bit sample, or as a spurious strobe.

// File: rtl/mon_link_pkg.sv
package mon_link_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

endpackage

// File: rtl/mlink_sync.sv
module mlink_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mlink_rx.sv
module mlink_rx
  import mon_link_pkg::*;
#(
  parameter int BIT_CYC = 278,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ferr_o,
  output logic              brk_o
);

  localparam int HALF = BIT_CYC / 2;
  localparam int CW   = $clog2(BIT_CYC);
  localparam int IW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_t         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              prev_q;
  logic              valid_q, valid_d;
  logic              ferr_q, ferr_d;
  logic              brk_q, brk_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    data_d  = data_q;
    valid_d = 1'b0;
    ferr_d  = 1'b0;
    brk_d   = 1'b0;
    if (!en_i) begin
      state_d = RX_IDLE;
    end else begin
      case (state_q)
        RX_IDLE: begin
          if (prev_q && !rxd_i) begin
            state_d = RX_START;
            cnt_d   = CW'(HALF - 1);
          end
        end
        RX_START: begin
          if (cnt_q == '0) begin
            if (!rxd_i) begin
              state_d = RX_DATA;
              cnt_d   = CW'(BIT_CYC - 1);
              idx_d   = '0;
            end else begin
              state_d = RX_IDLE;
            end
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == '0) begin
            sh_d  = {rxd_i, sh_q[DATA_W-1:1]};
            cnt_d = CW'(BIT_CYC - 1);
            if (idx_q == IW'(DATA_W - 1)) state_d = RX_STOP;
            else                          idx_d   = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == '0) begin
            state_d = RX_IDLE;
            if (rxd_i) begin
              valid_d = 1'b1;
              data_d  = sh_q;
            end else if (sh_q == '0) begin
              brk_d = 1'b1;
            end else begin
              ferr_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      prev_q  <= 1'b1;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      data_q  <= data_d;
      prev_q  <= rxd_i;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
      brk_q   <= brk_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign ferr_o  = ferr_q;
  assign brk_o   = brk_q;

  // R3: a byte is only reported when the sampled stop level was high
  assert_valid_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(rxd_i));

  // R5, R6: at most one kind of result per frame
  assert_one_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({valid_o, ferr_o, brk_o}));

  // R6: dropped frames leave the delivered byte untouched
  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_o || brk_o) |-> $stable(data_o));

  // R9: no result follows a cycle in which reception was locked out
  assert_locked_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !(valid_o || ferr_o || brk_o));

endmodule

// File: rtl/mlink_tx.sv
module mlink_tx #(
  parameter int BIT_CYC = 278,
  parameter int FRAME_W = 12,
  parameter int LW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LW-1:0]      len_i,
  output logic               active_o,
  output logic               line_o
);

  localparam int CW = $clog2(BIT_CYC);

  logic               act_q, act_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [LW-1:0]      left_q, left_d;
  logic [CW-1:0]      cnt_q, cnt_d;

  always_comb begin
    act_d  = act_q;
    sh_d   = sh_q;
    left_d = left_q;
    cnt_d  = cnt_q;
    if (!act_q) begin
      if (load_i) begin
        act_d  = 1'b1;
        sh_d   = frame_i;
        left_d = len_i;
        cnt_d  = CW'(BIT_CYC - 1);
      end
    end else if (cnt_q == '0) begin
      sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
      cnt_d  = CW'(BIT_CYC - 1);
      left_d = left_q - 1'b1;
      if (left_q == LW'(1)) act_d = 1'b0;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      cnt_q  <= cnt_d;
    end
  end

  assign active_o = act_q;
  assign line_o   = act_q ? sh_q[0] : 1'b1;

  // R1: the driven level only moves at a bit boundary
  assert_bit_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q != '0) |=> $stable(line_o));

endmodule

// File: rtl/mon_serial_link.sv
module mon_serial_link #(
  parameter int BIT_CYC   = 278,
  parameter int DATA_W    = 8,
  parameter int GAP_BITS  = 2,
  parameter int ECHO_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  output logic              line_out,
  output logic              line_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_ferr,
  output logic              brk_det,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_start,
  output logic              tx_busy
);

  localparam int BYTE_BITS = DATA_W + 2;
  localparam int BRK_BITS  = GAP_BITS + ECHO_BITS;
  localparam int FRAME_W   = (BYTE_BITS > BRK_BITS) ? BYTE_BITS : BRK_BITS;
  localparam int LW        = $clog2(FRAME_W + 1);
  localparam logic [FRAME_W-1:0] BRK_FRAME = FRAME_W'((1 << GAP_BITS) - 1);

  logic               rst_n_s;
  logic               rxd_s;
  logic               tx_act;
  logic               tx_line;
  logic               rx_brk;
  logic               load;
  logic [FRAME_W-1:0] frame;
  logic [LW-1:0]      len;

  mlink_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_n_s)
  );

  mlink_sync #(.STAGES(2), .RST_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(line_in), .q_o(rxd_s)
  );

  mlink_rx #(.BIT_CYC(BIT_CYC), .DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en_i    (!tx_act),
    .rxd_i   (rxd_s),
    .data_o  (rx_data),
    .valid_o (rx_valid),
    .ferr_o  (rx_ferr),
    .brk_o   (rx_brk)
  );

  // A break pulse takes priority over a host request in the same cycle.
  always_comb begin
    if (rx_brk) begin
      frame = BRK_FRAME;
      len   = LW'(BRK_BITS);
    end else begin
      frame = FRAME_W'({1'b1, tx_data, 1'b0});
      len   = LW'(BYTE_BITS);
    end
    load = rx_brk || (tx_start && !tx_act);
  end

  mlink_tx #(.BIT_CYC(BIT_CYC), .FRAME_W(FRAME_W), .LW(LW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_i   (load),
    .frame_i  (frame),
    .len_i    (len),
    .active_o (tx_act),
    .line_o   (tx_line)
  );

  assign line_out = tx_line;
  assign line_oe  = tx_act;
  assign tx_busy  = tx_act;
  assign brk_det  = rx_brk;

  // R7: the response opens with the line driven high
  assert_brk_resp_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    brk_det |=> (line_oe && line_out));

  // R2: an accepted request begins with a driven low start bit
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tx_start && !tx_busy && !brk_det) |=> (line_oe && !line_out));

  // R8: a request while busy does not restart the frame
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tx_start && tx_busy && $past(tx_busy)) |=> !$rose(tx_busy));

endmodule

// File: tb/tb_mon_serial_link.sv
module tb_mon_serial_link;

  localparam int BIT = 278;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host;
  logic       line_in;
  logic       line_out, line_oe;
  logic [7:0] rx_data;
  logic       rx_valid, rx_ferr, brk_det;
  logic [7:0] tx_data;
  logic       tx_start;
  logic       tx_busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_val = 0, n_fe = 0, n_brk = 0, brk_cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign line_in = (line_oe ? line_out : 1'b1) & host;

  mon_serial_link dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_out(line_out),
    .line_oe(line_oe), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ferr(rx_ferr), .brk_det(brk_det), .tx_data(tx_data),
    .tx_start(tx_start), .tx_busy(tx_busy)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) n_val++;
      if (rx_ferr)  n_fe++;
      if (brk_det) begin n_brk++; brk_cyc = cyc; end
    end
  end

  // vector: {kind[1:0], stop, data[7:0]}; kind 0 = byte, 1 = framing error, 2 = break
  localparam logic [10:0] VEC [8] = '{
    {2'd0, 1'b1, 8'hA5}, {2'd0, 1'b1, 8'h00}, {2'd0, 1'b1, 8'hFF},
    {2'd0, 1'b1, 8'h01}, {2'd1, 1'b0, 8'h3C}, {2'd0, 1'b1, 8'h80},
    {2'd2, 1'b0, 8'h00}, {2'd0, 1'b1, 8'h5A}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop);
    for (int i = 0; i < 10; i++) begin
      host = (i == 0) ? 1'b0 : (i == 9) ? stop : d[i-1];
      repeat (BIT) @(negedge clk);
    end
    host = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v0, f0, b0, t0;
    logic [7:0] last;
    rst_n = 1'b0; host = 1'b1; tx_data = '0; tx_start = 1'b0;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(!line_oe && !tx_busy, "R10 oe/busy in reset", {line_oe, tx_busy}, 0);
    check(!rx_valid && !rx_ferr && !brk_det, "R10 strobes in reset",
          {rx_valid, rx_ferr, brk_det}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(!line_oe && !tx_busy && rx_data == 8'h00, "R10 state after reset",
          {line_oe, tx_busy, rx_data}, 0);

    // R3 R5 R6: table of received frames
    last = 8'h00;
    foreach (VEC[k]) begin
      v0 = n_val; f0 = n_fe; b0 = n_brk;
      send_frame(VEC[k][7:0], VEC[k][8]);
      repeat (2 * BIT) @(negedge clk);
      if (VEC[k][10:9] == 2'd2) repeat (3600) @(negedge clk);
      case (VEC[k][10:9])
        2'd0: begin
          last = VEC[k][7:0];
          check(n_val == v0 + 1 && n_fe == f0 && n_brk == b0, "R3 byte strobe",
                n_val - v0, 1);
        end
        2'd1: check(n_fe == f0 + 1 && n_val == v0 && n_brk == b0, "R6 framing error strobe",
                    n_fe - f0, 1);
        default: check(n_brk == b0 + 1 && n_val == v0 && n_fe == f0, "R5 break strobe",
                       n_brk - b0, 1);
      endcase
      check(rx_data == last, "R3 R5 R6 rx_data", rx_data, last);
    end

    // R2 R8 R1: transmit with a rejected second request
    @(negedge clk);
    tx_data = 8'hC3; tx_start = 1'b1; t0 = cyc + 1;
    @(negedge clk);
    tx_start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      logic e;
      if (i == 4) begin
        wait_until(t0 + 1000);
        tx_data = 8'h00; tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
      end
      e = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : tx_data == 8'h00 ? 8'hC3 >> (i - 1) & 1 : 1'b0;
      e = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : 1'((8'hC3 >> (i - 1)) & 8'h01);
      wait_until(t0 + BIT * i + BIT / 2);
      check(line_oe && line_out == e, "R2 tx bit level", {line_oe, line_out}, {1'b1, e});
    end
    wait_until(t0 + 10 * BIT - 1);
    check(tx_busy && line_oe, "R8 busy through stop bit", tx_busy, 1);
    wait_until(t0 + 10 * BIT);
    check(!tx_busy && !line_oe, "R1 R8 busy ends after 2780 cycles", tx_busy, 0);
    repeat (20) @(negedge clk);
    check(!tx_busy, "R8 request while busy ignored", tx_busy, 0);

    // R7: break response timing
    send_frame(8'h00, 1'b0);
    t0 = brk_cyc + 1;
    for (int i = 0; i < 12; i++) begin
      wait_until(t0 + BIT * i + BIT / 2);
      check(line_oe && tx_busy && line_out == (i < 2), "R7 response level",
            {line_oe, tx_busy, line_out}, {2'b11, 1'(i < 2)});
    end
    wait_until(t0 + 12 * BIT - 1);
    check(line_oe && !line_out, "R7 echo held to end", {line_oe, line_out}, 2);
    wait_until(t0 + 12 * BIT);
    check(!line_oe && !tx_busy, "R7 line released", line_oe, 0);
    repeat (BIT) @(negedge clk);

    // R4: short glitch rejected, then a good frame
    v0 = n_val; f0 = n_fe; b0 = n_brk;
    host = 1'b0; repeat (60) @(negedge clk); host = 1'b1;
    repeat (800) @(negedge clk);
    check(n_val == v0 && n_fe == f0 && n_brk == b0, "R4 glitch ignored",
          (n_val - v0) + (n_fe - f0) + (n_brk - b0), 0);
    send_frame(8'h7E, 1'b1);
    repeat (BIT) @(negedge clk);
    check(n_val == v0 + 1 && rx_data == 8'h7E, "R3 R4 frame after glitch", rx_data, 8'h7E);

    // R9: line activity during transmit is ignored
    v0 = n_val; f0 = n_fe; b0 = n_brk;
    tx_data = 8'h55; tx_start = 1'b1; t0 = cyc + 1;
    @(negedge clk);
    tx_start = 1'b0;
    wait_until(t0 + 500);  host = 1'b0;
    wait_until(t0 + 1100); host = 1'b1;
    wait_until(t0 + 10 * BIT + 600);
    check(n_val == v0 && n_fe == f0 && n_brk == b0, "R9 receiver locked out",
          (n_val - v0) + (n_fe - f0) + (n_brk - b0), 0);
    check(rx_data == 8'h7E, "R9 rx_data kept", rx_data, 8'h7E);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule